// File: doc/BRIEF.md
# UART Transmit Path with Character Timer

This block is the transmit half of a classic byte-oriented UART. Software-side byte writes land in a holding buffer. The buffer behaves as a single holding register in character mode and as a first-in first-out queue in queue mode. The oldest entry moves into a shift register, which stays occupied for one computed character time. When that time ends the block emits the byte as a one-cycle completion strobe with the data alongside.

The character time is derived from the frame format and the baud divisor. The block reports whether the holding buffer is empty and whether the shifter is idle. It keeps a transmit-empty interrupt pending flag for the interrupt logic next to it. A break control turns loaded entries into break events. A loopback control diverts completed characters into an internal loopback register instead of the output strobe.

Top module: `uart_tx_path`

## Requirements
- R1: After reset, thr_empty and tsr_empty are 1, and tx_irq_pend, char_done and break_done are 0.
- R2: A character keeps the shifter busy for C clock cycles, counted from the cycle tsr_empty falls to the cycle char_done is seen. C = ((divisor × H) >> 1) × TICK_DIV, and C = 1 when that product is 0. H counts half-bit units: 2 × (1 + data bits), plus 2 when parity_en is 1, plus the stop part. Data bits = 5 + word_len. The stop part is 4 when two_stop is 1, 3 for a 5-bit word, and 2 otherwise. Format and divisor are taken at the moment of loading.
- R3: A write into an empty buffer while the shifter is idle loads the shift register on the next clock. tsr_empty stays 1 for the cycle after the write and is 0 the cycle after that.
- R4: Entries leave in write order. When a character completes with the buffer non-empty, the next entry loads in the same clock, so tsr_empty does not rise between them.
- R5: When a character completes with the buffer empty, tsr_empty returns to 1. Each character gives exactly one char_done pulse, and char_data holds the byte.
- R6: Buffer capacity is 1 when fifo_mode is 0 and FIFO_DEPTH when fifo_mode is 1. A write into a full buffer replaces the entry at the write position without advancing it. In character mode the last write wins. In queue mode the oldest waiting entry is replaced.
- R7: A load that leaves the buffer empty sets thr_empty and tx_irq_pend. Any write clears both, and a write takes precedence over that setting.
- R8: A fifo_clr pulse discards all waiting entries and sets thr_empty. It sets tx_irq_pend to the value of fifo_mode. A character already in the shifter still completes.
- R9: A change of fifo_mode acts as a clear (R8) in the same cycle, so tx_irq_pend becomes 1 on a switch into queue mode and 0 on a switch into character mode.
- R10: An entry loaded while break_en is 1 is consumed as one break event. break_done pulses one cycle after the load, and no char_done is produced.
- R11: break_en rising while a character is in the shifter converts that character into a break event. break_done pulses on the next cycle, and no char_done is produced for it.
- R12: break_en falling while the shifter is busy restarts a normal character with the same byte and a fresh full character time (R2). char_done then appears C + 1 cycles after the cycle in which break_en returns to 0.
- R13: With loop_en at 1 when a character completes, the byte goes to loop_data and char_done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr | input | 1 | Write strobe for the holding buffer |
| thr_data | input | DATA_W | Byte written with thr_wr |
| word_len | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | 1 selects the long stop period |
| parity_en | input | 1 | 1 adds a parity bit to the frame |
| break_en | input | 1 | Break control |
| divisor | input | DIV_W | Baud divisor |
| fifo_mode | input | 1 | 0 = single holding register, 1 = FIFO_DEPTH queue |
| fifo_clr | input | 1 | One-cycle clear of the holding buffer |
| loop_en | input | 1 | Divert completed characters to loop_data |
| thr_empty | output | 1 | Holding buffer empty |
| tsr_empty | output | 1 | Shift register idle |
| tx_irq_pend | output | 1 | Transmit-empty interrupt pending |
| char_done | output | 1 | One-cycle pulse when a character completes |
| char_data | output | DATA_W | Byte of the last completed character |
| break_done | output | 1 | One-cycle pulse when a break event completes |
| loop_data | output | DATA_W | Last byte completed in loopback |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and TICK_DIV = 2. With these values the queue fills after four writes, so the overwrite-when-full rule can be reached in a few cycles. A full character lasts only tens of cycles at divisors 0 to 3. Divisor 0 brings the one-cycle minimum within reach. The short character time also leaves a wide window for break toggles and back-to-back loads.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef struct packed {
    logic [1:0] wlen;
    logic       two_stop;
    logic       par_en;
  } frame_fmt_t;

  // Half-bit units in one frame: start, data, optional parity, stop.
  function automatic logic [4:0] half_bit_count(frame_fmt_t f);
    logic [4:0] n;
    n = 5'd12 + {2'b00, f.wlen, 1'b0};
    if (f.par_en) n = n + 5'd2;
    if (f.two_stop) n = n + 5'd4;
    else if (f.wlen != 2'd0) n = n + 5'd2;
    else n = n + 5'd3;
    return n;
  endfunction

  // Core clocks the shifter stays busy; never less than one.
  function automatic logic [31:0] frame_clocks(frame_fmt_t f, logic [31:0] div,
                                               logic [31:0] tick);
    logic [31:0] t;
    t = (div * {27'd0, half_bit_count(f)}) >> 1;
    t = t * tick;
    if (t == 32'd0) t = 32'd1;
    return t;
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      deep,
  input  logic                      push,
  input  logic [DATA_W-1:0]         push_data,
  input  logic                      pop,
  output logic [DATA_W-1:0]         head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;
  logic              full;
  logic              grow;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p, logic wide);
    if (!wide || p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign limit = deep ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full  = (cnt_q >= limit);
  assign grow  = push && !full;
  assign head  = mem[rd_ptr];
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop)  rd_ptr <= bump(rd_ptr, deep);
      if (grow) wr_ptr <= bump(wr_ptr, deep);
      case ({grow, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_timer.sv
module uart_tx_timer #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TMR_W-1:0] start_val,
  output logic             busy,
  output logic             fin
);
  logic [TMR_W-1:0] cnt_q;

  assign fin = busy && (cnt_q == TMR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= start_val;
    end else if (fin) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int TICK_DIV   = 16,
  parameter int DIV_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_wr,
  input  logic [DATA_W-1:0] thr_data,
  input  logic [1:0]        word_len,
  input  logic              two_stop,
  input  logic              parity_en,
  input  logic              break_en,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              fifo_mode,
  input  logic              fifo_clr,
  input  logic              loop_en,
  output logic              thr_empty,
  output logic              tsr_empty,
  output logic              tx_irq_pend,
  output logic              char_done,
  output logic [DATA_W-1:0] char_data,
  output logic              break_done,
  output logic [DATA_W-1:0] loop_data
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int TMR_W = 32;

  // Named internal events, also observed by the checker.
  logic              clr_evt;
  logic              brk_edge;
  logic              fin_evt;
  logic              fin_ok;
  logic              load_evt;
  logic              drain_evt;
  logic              tmr_start;
  logic              tmr_busy;
  logic              emit_char;
  logic              emit_loop;
  logic              emit_break;
  logic [CNT_W-1:0]  fifo_count;
  logic [DATA_W-1:0] fifo_head;
  logic [TMR_W-1:0]  frame_clk;
  logic [TMR_W-1:0]  start_val;
  frame_fmt_t        fmt;

  logic              brk_q, mode_q, is_brk_q;
  logic [DATA_W-1:0] shift_q;
  logic              thr_empty_q, pend_q;
  logic              char_done_q, break_done_q;
  logic [DATA_W-1:0] char_data_q, loop_q;

  assign fmt       = '{wlen: word_len, two_stop: two_stop, par_en: parity_en};
  assign frame_clk = frame_clocks(fmt, 32'(divisor), 32'(TICK_DIV));

  assign clr_evt   = fifo_clr || (fifo_mode != mode_q);
  assign brk_edge  = tmr_busy && (break_en != brk_q);
  assign fin_ok    = fin_evt && !brk_edge;
  assign load_evt  = !clr_evt && (fifo_count != '0) && (!tmr_busy || fin_ok);
  assign drain_evt = load_evt && (fifo_count == CNT_W'(1));
  assign tmr_start = load_evt || brk_edge;
  assign start_val = break_en ? TMR_W'(1) : frame_clk;

  assign emit_break = fin_ok && is_brk_q;
  assign emit_char  = fin_ok && !is_brk_q && !loop_en;
  assign emit_loop  = fin_ok && !is_brk_q && loop_en;

  uart_tx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_evt),
    .deep      (fifo_mode),
    .push      (thr_wr),
    .push_data (thr_data),
    .pop       (load_evt),
    .head      (fifo_head),
    .count     (fifo_count)
  );

  uart_tx_timer #(.TMR_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (tmr_start),
    .start_val (start_val),
    .busy      (tmr_busy),
    .fin       (fin_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q        <= 1'b0;
      mode_q       <= 1'b0;
      is_brk_q     <= 1'b0;
      shift_q      <= '0;
      thr_empty_q  <= 1'b1;
      pend_q       <= 1'b0;
      char_done_q  <= 1'b0;
      break_done_q <= 1'b0;
      char_data_q  <= '0;
      loop_q       <= '0;
    end else begin
      brk_q        <= break_en;
      mode_q       <= fifo_mode;
      char_done_q  <= emit_char;
      break_done_q <= emit_break;
      if (emit_char) char_data_q <= shift_q;
      if (emit_loop) loop_q <= shift_q;
      if (load_evt)  shift_q <= fifo_head;
      if (tmr_start) is_brk_q <= break_en;
      if (clr_evt) begin
        thr_empty_q <= 1'b1;
        pend_q      <= fifo_mode;
      end else if (thr_wr) begin
        thr_empty_q <= 1'b0;
        pend_q      <= 1'b0;
      end else if (drain_evt) begin
        thr_empty_q <= 1'b1;
        pend_q      <= 1'b1;
      end
    end
  end

  assign thr_empty   = thr_empty_q;
  assign tsr_empty   = !tmr_busy;
  assign tx_irq_pend = pend_q;
  assign char_done   = char_done_q;
  assign char_data   = char_data_q;
  assign break_done  = break_done_q;
  assign loop_data   = loop_q;
endmodule

// File: rtl/uart_tx_path_chk.sv
module uart_tx_path_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             thr_wr,
  input logic             fifo_clr,
  input logic             fifo_mode,
  input logic             loop_en,
  input logic             break_en,
  input logic             thr_empty,
  input logic             tsr_empty,
  input logic             tx_irq_pend,
  input logic             char_done,
  input logic             break_done,
  input logic             clr_evt,
  input logic [CNT_W-1:0] fifo_count
);
  // R6: occupancy never exceeds the capacity of the current mode
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_evt |-> fifo_count <= (fifo_mode ? CNT_W'(FIFO_DEPTH) : CNT_W'(1)));

  // R5: a completion strobe follows a busy shifter
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> $past(!tsr_empty));

  // R7: a write clears holding-empty and the pending flag
  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !clr_evt) |=> (!thr_empty && !tx_irq_pend));

  // R8: a clear empties the buffer and sets pending per mode
  a_r8_clear_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (thr_empty && (tx_irq_pend == $past(fifo_mode))));

  // R10: break events only complete with the break control set
  a_r10_break_bit: assert property (@(posedge clk) disable iff (!rst_n)
    break_done |-> $past(break_en));

  // R13: no output strobe for characters finished in loopback
  a_r13_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> !$past(loop_en));

  // R7: pending rises only together with an empty holding buffer
  a_r7_pend_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_irq_pend) |-> thr_empty);
endmodule

bind uart_tx_path uart_tx_path_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .thr_wr      (thr_wr),
  .fifo_clr    (fifo_clr),
  .fifo_mode   (fifo_mode),
  .loop_en     (loop_en),
  .break_en    (break_en),
  .thr_empty   (thr_empty),
  .tsr_empty   (tsr_empty),
  .tx_irq_pend (tx_irq_pend),
  .char_done   (char_done),
  .break_done  (break_done),
  .clr_evt     (clr_evt),
  .fifo_count  (fifo_count)
);

// File: tb/sim_uart_tx_path.sv
`timescale 1ns/1ps
module sim_uart_tx_path;
  localparam int DW = 8;
  localparam int FD = 4;
  localparam int TK = 2;
  localparam int VW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_wr = 1'b0;
  logic [DW-1:0] thr_data = '0;
  logic [1:0] word_len = 2'd3;
  logic two_stop = 1'b0, parity_en = 1'b0, break_en = 1'b0;
  logic [VW-1:0] divisor = 16'd1;
  logic fifo_mode = 1'b0, fifo_clr = 1'b0, loop_en = 1'b0;
  logic thr_empty, tsr_empty, tx_irq_pend, char_done, break_done;
  logic [DW-1:0] char_data, loop_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_tx_path #(.DATA_W(DW), .FIFO_DEPTH(FD), .TICK_DIV(TK), .DIV_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_data(thr_data),
    .word_len(word_len), .two_stop(two_stop), .parity_en(parity_en),
    .break_en(break_en), .divisor(divisor), .fifo_mode(fifo_mode),
    .fifo_clr(fifo_clr), .loop_en(loop_en), .thr_empty(thr_empty),
    .tsr_empty(tsr_empty), .tx_irq_pend(tx_irq_pend), .char_done(char_done),
    .char_data(char_data), .break_done(break_done), .loop_data(loop_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected character duration restated from bit counts (R2).
  function automatic int exp_clk(input int wl, input int st, input int par, input int dv);
    int dbits, halves, t;
    dbits  = 5 + wl;
    halves = 2 * (1 + dbits) + (par != 0 ? 2 : 0);
    if (st != 0) halves += 4;
    else if (dbits == 5) halves += 3;
    else halves += 2;
    t = ((dv * halves) / 2) * TK;
    return (t == 0) ? 1 : t;
  endfunction

  // Behavioural reference model.
  logic [7:0] mq[$];
  bit m_busy, m_isb, m_thr, m_pend, m_cd, m_bd, m_bq, m_mode;
  int m_cnt;
  logic [7:0] m_sh, m_cdat, m_loop;

  always @(posedge clk) begin : model
    bit clr, fin, edg, fine, ld;
    int n0, lim, full_t;
    logic [7:0] h;
    if (!rst_n) begin
      mq.delete();
      m_busy = 0; m_isb = 0; m_thr = 1; m_pend = 0; m_cd = 0; m_bd = 0;
      m_bq = 0; m_mode = 0; m_cnt = 0; m_sh = 0; m_cdat = 0; m_loop = 0;
    end else begin
      h = 8'h00;
      full_t = exp_clk(int'(word_len), int'(two_stop), int'(parity_en), int'(divisor));
      clr  = fifo_clr || (fifo_mode != m_mode);
      fin  = m_busy && (m_cnt == 1);
      edg  = m_busy && (break_en != m_bq);
      fine = fin && !edg;
      n0   = mq.size();
      lim  = fifo_mode ? FD : 1;
      ld   = !clr && (n0 != 0) && (!m_busy || fine);
      m_cd = 0; m_bd = 0;
      if (fine) begin
        if (m_isb) m_bd = 1;
        else if (loop_en) m_loop = m_sh;
        else begin m_cd = 1; m_cdat = m_sh; end
      end
      if (clr) begin
        mq.delete(); m_thr = 1; m_pend = fifo_mode;
      end else begin
        if (ld) h = mq.pop_front();
        if (thr_wr) begin
          if (n0 < lim) mq.push_back(thr_data);
          else if (!ld) mq[0] = thr_data;
        end
        if (thr_wr) begin m_thr = 0; m_pend = 0; end
        else if (ld && n0 == 1) begin m_thr = 1; m_pend = 1; end
      end
      if (ld) begin
        m_sh = h; m_isb = break_en; m_busy = 1; m_cnt = break_en ? 1 : full_t;
      end else if (edg) begin
        m_busy = 1; m_isb = break_en; m_cnt = break_en ? 1 : full_t;
      end else if (fin) begin
        m_busy = 0; m_cnt = 0;
      end else if (m_busy) begin
        m_cnt--;
      end
      m_bq = break_en; m_mode = fifo_mode;
    end
  end

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(thr_empty == m_thr, "R7 thr_empty", int'(thr_empty), int'(m_thr));
      chk(tsr_empty == !m_busy, "R3 tsr_empty", int'(tsr_empty), int'(!m_busy));
      chk(tx_irq_pend == m_pend, "R7 tx_irq_pend", int'(tx_irq_pend), int'(m_pend));
      chk(char_done == m_cd, "R2 char_done", int'(char_done), int'(m_cd));
      chk(break_done == m_bd, "R10 break_done", int'(break_done), int'(m_bd));
      chk(loop_data == m_loop, "R13 loop_data", int'(loop_data), int'(m_loop));
      if (char_done) chk(char_data == m_cdat, "R4 char_data", int'(char_data), int'(m_cdat));
    end
  end

  // Output log.
  logic [7:0] got[$];
  int nbrk = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (char_done) got.push_back(char_data);
      if (break_done) nbrk++;
    end
  end

  task automatic wr(input logic [7:0] d);
    thr_data = d;
    thr_wr = 1'b1;
    @(negedge clk);
    thr_wr = 1'b0;
  endtask

  task automatic idle();
    while (!(tsr_empty && thr_empty)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic timed(input logic [7:0] d, input int exp, input string tag);
    int n;
    wr(d);
    chk(tsr_empty == 1'b1, "R3 not yet loaded", int'(tsr_empty), 1);
    @(negedge clk);
    chk(tsr_empty == 1'b0, "R3 loaded next cycle", int'(tsr_empty), 0);
    chk(thr_empty && tx_irq_pend, "R7 drain sets flags", int'({thr_empty, tx_irq_pend}), 3);
    n = 0;
    while (!char_done) begin @(negedge clk); n++; end
    chk(n == exp, tag, n, exp);
    chk(char_data == d, "R5 char_data", int'(char_data), int'(d));
    @(negedge clk);
    chk(tsr_empty == 1'b1, "R5 shifter idle", int'(tsr_empty), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(thr_empty == 1'b1, "R1 thr_empty", int'(thr_empty), 1);
    chk(tsr_empty == 1'b1, "R1 tsr_empty", int'(tsr_empty), 1);
    chk(tx_irq_pend == 1'b0, "R1 tx_irq_pend", int'(tx_irq_pend), 0);
    chk(!char_done && !break_done, "R1 strobes", int'({char_done, break_done}), 0);

    // R2: durations over several formats
    word_len = 2'd3; two_stop = 0; parity_en = 0; divisor = 16'd1;
    timed(8'h41, exp_clk(3, 0, 0, 1), "R2 8N1 div1");
    word_len = 2'd0;
    timed(8'h1A, exp_clk(0, 0, 0, 1), "R2 5N1 div1");
    word_len = 2'd3; two_stop = 1; parity_en = 1;
    timed(8'hC3, exp_clk(3, 1, 1, 1), "R2 8P2 div1");
    parity_en = 0; divisor = 16'd3;
    timed(8'h5A, exp_clk(3, 1, 0, 3), "R2 8N2 div3");
    word_len = 2'd2; two_stop = 0; parity_en = 1; divisor = 16'd0;
    timed(8'h33, 1, "R2 div0 minimum");
    word_len = 2'd3; two_stop = 0; parity_en = 0; divisor = 16'd1;
    idle();

    // R6: character mode, last write wins
    got.delete();
    wr(8'h41); repeat (3) @(negedge clk);
    wr(8'h42);
    chk(!thr_empty && !tx_irq_pend, "R7 write clears", int'({thr_empty, tx_irq_pend}), 0);
    wr(8'h43);
    idle();
    chk(got.size() == 2, "R6 char mode count", got.size(), 2);
    if (got.size() == 2) begin
      chk(got[0] == 8'h41, "R6 first byte", int'(got[0]), 'h41);
      chk(got[1] == 8'h43, "R6 overwrite byte", int'(got[1]), 'h43);
    end

    // R9: switch into queue mode discards a waiting byte
    got.delete();
    wr(8'h10); repeat (2) @(negedge clk);
    wr(8'h11);
    fifo_mode = 1'b1;
    @(negedge clk);
    chk(thr_empty && tx_irq_pend, "R9 into queue mode", int'({thr_empty, tx_irq_pend}), 3);
    idle();
    chk(got.size() == 1 && got[0] == 8'h10, "R9 waiting byte dropped", got.size(), 1);

    // R4 / R6: queue order, overwrite of oldest when full
    got.delete();
    wr(8'h20); repeat (2) @(negedge clk);
    wr(8'h21); wr(8'h22); wr(8'h23); wr(8'h24);
    wr(8'h25);
    while (!char_done) @(negedge clk);
    @(negedge clk);
    chk(tsr_empty == 1'b0, "R4 back-to-back load", int'(tsr_empty), 0);
    idle();
    chk(got.size() == 5, "R6 queue count", got.size(), 5);
    if (got.size() == 5) begin
      chk(got[0] == 8'h20, "R4 order 0", int'(got[0]), 'h20);
      chk(got[1] == 8'h25, "R6 oldest replaced", int'(got[1]), 'h25);
      chk(got[2] == 8'h22, "R4 order 2", int'(got[2]), 'h22);
      chk(got[4] == 8'h24, "R4 order 4", int'(got[4]), 'h24);
    end

    // R8: clear in queue mode
    got.delete();
    wr(8'h30); wr(8'h31); wr(8'h32);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    chk(thr_empty && tx_irq_pend, "R8 clear flags", int'({thr_empty, tx_irq_pend}), 3);
    chk(tsr_empty == 1'b0, "R8 current char kept", int'(tsr_empty), 0);
    idle();
    chk(got.size() == 1 && got[0] == 8'h30, "R8 only shifter byte sent", got.size(), 1);

    // R9: back to character mode clears pending
    fifo_mode = 1'b0;
    @(negedge clk);
    chk(tx_irq_pend == 1'b0, "R9 into char mode", int'(tx_irq_pend), 0);
    chk(thr_empty == 1'b1, "R9 empty after switch", int'(thr_empty), 1);

    // R10: entry loaded during break
    got.delete(); nbrk = 0;
    break_en = 1'b1;
    wr(8'h50);
    repeat (3) @(negedge clk);
    chk(nbrk == 1, "R10 one break event", nbrk, 1);
    chk(got.size() == 0, "R10 no character", got.size(), 0);
    break_en = 1'b0;
    idle();

    // R11: break rising during a character
    got.delete(); nbrk = 0;
    wr(8'h60);
    repeat (5) @(negedge clk);
    break_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(nbrk == 1, "R11 converted to break", nbrk, 1);
    chk(got.size() == 0, "R11 no character", got.size(), 0);
    break_en = 1'b0;
    idle();

    // R12: break falling while busy restarts the character
    got.delete(); nbrk = 0;
    wr(8'h70);
    repeat (5) @(negedge clk);
    break_en = 1'b1;
    @(negedge clk);
    break_en = 1'b0;
    n = 0;
    while (!char_done) begin @(negedge clk); n++; end
    chk(n == exp_clk(3, 0, 0, 1) + 1, "R12 restart time", n, exp_clk(3, 0, 0, 1) + 1);
    chk(char_data == 8'h70, "R12 same byte", int'(char_data), 'h70);
    idle();
    chk(nbrk == 0, "R12 no break event", nbrk, 0);

    // R13: loopback
    got.delete();
    loop_en = 1'b1;
    wr(8'h99);
    @(negedge clk);
    idle();
    chk(loop_data == 8'h99, "R13 loop_data", int'(loop_data), 'h99);
    chk(got.size() == 0, "R13 no char_done", got.size(), 0);
    loop_en = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule